// File: doc/BRIEF.md
# External Bus Ownership Controller

This block sits on the processor side of a shared external bus and settles, cycle by cycle, whether the processor or an outside agent owns it. It accepts one internal access request at a time. It runs that access as one address-strobe cycle followed by a fixed number of data beats. It drives output enables for the address, data and control pins, and for three per-access attribute pins: data/code, DMA and supervisor. Any pin whose enable is low is taken to float.

Two mechanisms take the bus away from the processor. The backoff input stops an access at once and floats every pin. When backoff is released, the access restarts with a fresh address strobe and finishes its remaining beats. A hold request from an outside agent is granted only between accesses. Hold is also granted while reset is active. The bus-request output stays driven throughout, so the outside agent can see when the processor wants the bus back.

Top module: `bus_own_ctrl`

## Requirements
- R1: In any cycle in which `backoff` is high, `addr_oe`, `data_oe`, `ctl_oe`, `attr_oe` and `addr_strobe` are all low and `acc_done` is low. A data beat seen under backoff is not counted.
- R2: An access stopped by backoff, with no hold request pending, shows `addr_strobe` high in the cycle after the first clock edge at which `backoff` is sampled low. It then completes exactly the beats it had not finished.
- R3: While `hold_ack` is high, `addr_oe`, `data_oe`, `ctl_oe`, `attr_oe` and `addr_strobe` are low.
- R4: A `hold_req` sampled high while `bus_reset` is high sets `hold_ack` high in the next cycle. `hold_ack` does not depend on reset.
- R5: `bus_req` is 1 whenever `acc_req` is high, an access is under way or suspended, or a suspended access awaits resumption, including during hold. `bus_req` is 0 whenever `bus_reset` is high.
- R6: While it drives, the block shows 1 on `attr_dc` for a data access, 1 on `attr_dma` for a DMA access and 1 on `attr_sup` for a supervisor access, and 0 otherwise. `attr_oe` is 1 only during the address and data cycles of an access, and it is 0 during hold and reset.
- R7: `attr_dc` and `wr_dir` (1 = write) take their new values on the same clock edge: the edge at which the access is accepted. They hold those values at all other edges.
- R8: A hold request that arrives during an access is not granted before that access's last beat (`acc_done`). It is granted in the cycle after that beat.
- R9: If backoff and hold are both requested, hold is granted only in the cycle after backoff is released, with no address strobe. The suspended access restarts after hold has ended.
- R10: `hold_ack` falls in the cycle after the first edge at which `hold_req` is sampled low. In that cycle no pin enable or strobe is active. The earliest address strobe comes one cycle later.
- R11: An access whose `acc_req` is high while the block is idle, with no hold request, shows `acc_accept` in that cycle. One `addr_strobe` cycle follows, then BEATS data cycles with `acc_done` on the last. `addr_oe` and `ctl_oe` are high on all of these cycles, and `data_oe` is high on the data cycles only for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_reset | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | Internal access request, held until accepted |
| acc_is_data | input | 1 | 1 = data access, 0 = code fetch |
| acc_is_dma | input | 1 | 1 = access started by the DMA engine |
| acc_is_super | input | 1 | 1 = access made with supervisor privilege |
| acc_is_write | input | 1 | 1 = write, 0 = read |
| hold_req | input | 1 | Bus hold request from an outside agent |
| backoff | input | 1 | Suspend the current access and float the pins |
| acc_accept | output | 1 | Access request taken this cycle |
| acc_done | output | 1 | Last data beat of the access this cycle |
| hold_ack | output | 1 | Bus handed to the outside agent |
| bus_req | output | 1 | Processor has an access pending |
| addr_strobe | output | 1 | Address strobe |
| addr_oe | output | 1 | Address pin enable |
| data_oe | output | 1 | Data pin enable (writes only) |
| ctl_oe | output | 1 | Bus control pin enable |
| wr_dir | output | 1 | Direction, 1 = write |
| attr_oe | output | 1 | Attribute pin enable |
| attr_dc | output | 1 | Data/code attribute |
| attr_dma | output | 1 | DMA attribute |
| attr_sup | output | 1 | Supervisor attribute |

## Verification
The assertions assume that `acc_req` stays high until `acc_accept` and falls in the cycle after it. They also assume that all inputs are synchronous and settle well before each clock edge. Their checks are turned off while `bus_reset` is high. The bench drives every input just after a rising edge. It drops `acc_req` right after acceptance and raises backoff and hold only at cycles chosen within an access. It sweeps all sixteen attribute and direction combinations, and it places backoff at every beat position.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
    // Ownership phases of the bus interface
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // processor owns the bus, nothing running
        ST_ADDR = 3'd1,   // address strobe cycle
        ST_DATA = 3'd2,   // data beats
        ST_SUSP = 3'd3,   // access stopped by backoff
        ST_HOLD = 3'd4    // bus handed to an outside agent
    } own_state_e;

    typedef struct packed {
        logic dc;
        logic dma;
        logic sup;
        logic wr;
    } acc_attr_t;
endpackage

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
    import bus_own_pkg::*;
#(
    parameter int BEATS = 3
) (
    input  logic       clk,
    input  logic       bus_reset,
    input  logic       acc_req,
    input  logic       hold_req,
    input  logic       backoff,
    output own_state_e state_q,
    output logic       pend_q,
    output logic       accept,
    output logic       done
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

    typedef struct packed {
        own_state_e    st;
        logic          pend;
        logic [CW-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        accept = 1'b0;
        done   = 1'b0;
        if (bus_reset) begin
            // hold arbitration keeps running; access state is cleared
            r_d.st   = hold_req ? ST_HOLD : ST_IDLE;
            r_d.pend = 1'b0;
            r_d.cnt  = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (hold_req) begin
                        r_d.st = ST_HOLD;
                    end else if (r_q.pend) begin
                        r_d.st   = ST_ADDR;
                        r_d.pend = 1'b0;
                    end else if (acc_req) begin
                        accept  = 1'b1;
                        r_d.st  = ST_ADDR;
                        r_d.cnt = LAST_IDX;
                    end
                end
                ST_ADDR: begin
                    r_d.st = backoff ? ST_SUSP : ST_DATA;
                end
                ST_DATA: begin
                    if (backoff) begin
                        r_d.st = ST_SUSP;
                    end else if (r_q.cnt == '0) begin
                        done   = 1'b1;
                        r_d.st = hold_req ? ST_HOLD : ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (!backoff) begin
                        if (hold_req) begin
                            r_d.st   = ST_HOLD;
                            r_d.pend = 1'b1;
                        end else begin
                            r_d.st = ST_ADDR;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!hold_req) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_q = r_q.st;
    assign pend_q  = r_q.pend;

    // a new access is never taken while an outside agent asks for the bus
    assert_accept_not_in_hold_R8: assert property (@(posedge clk) disable iff (bus_reset)
        accept |-> !hold_req);

    // the beat counter only counts down while data is moving
    assert_count_frozen_R2: assert property (@(posedge clk) disable iff (bus_reset)
        (r_q.st == ST_SUSP) |=> $stable(r_q.cnt));
endmodule

// File: rtl/bus_own_attr.sv
module bus_own_attr
    import bus_own_pkg::*;
(
    input  logic      clk,
    input  logic      bus_reset,
    input  logic      accept,
    input  acc_attr_t attr_in,
    output acc_attr_t attr_q
);
    acc_attr_t attr_d;

    always_comb begin
        attr_d = attr_q;
        if (bus_reset)   attr_d = '0;
        else if (accept) attr_d = attr_in;
    end

    always_ff @(posedge clk) begin
        attr_q <= attr_d;
    end

    // attributes only move at the acceptance edge
    assert_attr_on_accept_R7: assert property (@(posedge clk) disable iff (bus_reset)
        !accept |=> $stable(attr_q));
endmodule

// File: rtl/bus_own_pins.sv
module bus_own_pins
    import bus_own_pkg::*;
(
    input  own_state_e state_q,
    input  logic       pend_q,
    input  logic       acc_req,
    input  logic       backoff,
    input  logic       bus_reset,
    input  acc_attr_t  attr_q,
    output logic       hold_ack,
    output logic       bus_req,
    output logic       addr_strobe,
    output logic       addr_oe,
    output logic       data_oe,
    output logic       ctl_oe,
    output logic       attr_oe
);
    logic in_access;
    logic own_drive;

    always_comb begin
        in_access   = (state_q == ST_ADDR) || (state_q == ST_DATA);
        own_drive   = in_access && !backoff && !bus_reset;
        hold_ack    = (state_q == ST_HOLD);
        addr_strobe = own_drive && (state_q == ST_ADDR);
        addr_oe     = own_drive;
        ctl_oe      = own_drive;
        attr_oe     = own_drive;
        data_oe     = own_drive && (state_q == ST_DATA) && attr_q.wr;
        bus_req     = !bus_reset &&
                      (acc_req || pend_q || in_access || (state_q == ST_SUSP));
    end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
    import bus_own_pkg::*;
#(
    parameter int BEATS = 3
) (
    input  logic clk,
    input  logic bus_reset,
    input  logic acc_req,
    input  logic acc_is_data,
    input  logic acc_is_dma,
    input  logic acc_is_super,
    input  logic acc_is_write,
    input  logic hold_req,
    input  logic backoff,
    output logic acc_accept,
    output logic acc_done,
    output logic hold_ack,
    output logic bus_req,
    output logic addr_strobe,
    output logic addr_oe,
    output logic data_oe,
    output logic ctl_oe,
    output logic wr_dir,
    output logic attr_oe,
    output logic attr_dc,
    output logic attr_dma,
    output logic attr_sup
);
    own_state_e state_q;
    logic       pend_q;
    acc_attr_t  attr_in;
    acc_attr_t  attr_q;

    assign attr_in = '{dc: acc_is_data, dma: acc_is_dma, sup: acc_is_super, wr: acc_is_write};

    bus_own_fsm #(.BEATS(BEATS)) u_fsm (
        .clk      (clk),
        .bus_reset(bus_reset),
        .acc_req  (acc_req),
        .hold_req (hold_req),
        .backoff  (backoff),
        .state_q  (state_q),
        .pend_q   (pend_q),
        .accept   (acc_accept),
        .done     (acc_done)
    );

    bus_own_attr u_attr (
        .clk      (clk),
        .bus_reset(bus_reset),
        .accept   (acc_accept),
        .attr_in  (attr_in),
        .attr_q   (attr_q)
    );

    bus_own_pins u_pins (
        .state_q    (state_q),
        .pend_q     (pend_q),
        .acc_req    (acc_req),
        .backoff    (backoff),
        .bus_reset  (bus_reset),
        .attr_q     (attr_q),
        .hold_ack   (hold_ack),
        .bus_req    (bus_req),
        .addr_strobe(addr_strobe),
        .addr_oe    (addr_oe),
        .data_oe    (data_oe),
        .ctl_oe     (ctl_oe),
        .attr_oe    (attr_oe)
    );

    assign wr_dir   = attr_q.wr;
    assign attr_dc  = attr_q.dc;
    assign attr_dma = attr_q.dma;
    assign attr_sup = attr_q.sup;

    assert_float_backoff_R1: assert property (@(posedge clk) disable iff (bus_reset)
        backoff |-> !(addr_oe || data_oe || ctl_oe || attr_oe || addr_strobe || acc_done));

    assert_resume_strobe_R2: assert property (@(posedge clk) disable iff (bus_reset)
        (state_q == ST_SUSP && !backoff && !hold_req) |=> (addr_strobe || backoff || bus_reset));

    assert_hold_float_R3: assert property (@(posedge clk) disable iff (bus_reset)
        hold_ack |-> !(addr_oe || data_oe || ctl_oe || attr_oe || addr_strobe));

    always_comb begin
        if (bus_reset) begin
            assert_bus_req_low_R5: assert (!bus_req);
        end
    end

    assert_dc_with_dir_R7: assert property (@(posedge clk) disable iff (bus_reset)
        !acc_accept |=> ($stable(attr_dc) && $stable(wr_dir)));

    assert_no_hold_mid_access_R8: assert property (@(posedge clk) disable iff (bus_reset)
        (state_q == ST_ADDR) |=> !hold_ack);

    assert_hold_after_backoff_R9: assert property (@(posedge clk) disable iff (bus_reset)
        (backoff && hold_req && state_q == ST_SUSP) |=> !hold_ack);

    assert_hold_drop_R10: assert property (@(posedge clk) disable iff (bus_reset)
        (hold_ack && !hold_req) |=> (!hold_ack && !addr_oe && !ctl_oe && !addr_strobe));
endmodule

// File: tb/bus_own_ctrl_bench.sv
module bus_own_ctrl_bench;
    localparam int BEATS = 3;

    logic clk = 1'b0;
    logic bus_reset, acc_req, acc_is_data, acc_is_dma, acc_is_super, acc_is_write;
    logic hold_req, backoff;
    logic acc_accept, acc_done, hold_ack, bus_req, addr_strobe, addr_oe, data_oe, ctl_oe;
    logic wr_dir, attr_oe, attr_dc, attr_dma, attr_sup;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_own_ctrl #(.BEATS(BEATS)) u_bus_own_ctrl (
        .clk(clk), .bus_reset(bus_reset), .acc_req(acc_req),
        .acc_is_data(acc_is_data), .acc_is_dma(acc_is_dma),
        .acc_is_super(acc_is_super), .acc_is_write(acc_is_write),
        .hold_req(hold_req), .backoff(backoff),
        .acc_accept(acc_accept), .acc_done(acc_done), .hold_ack(hold_ack),
        .bus_req(bus_req), .addr_strobe(addr_strobe), .addr_oe(addr_oe),
        .data_oe(data_oe), .ctl_oe(ctl_oe), .wr_dir(wr_dir), .attr_oe(attr_oe),
        .attr_dc(attr_dc), .attr_dma(attr_dma), .attr_sup(attr_sup)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    function automatic int drive_any();
        return int'(addr_oe | data_oe | ctl_oe | attr_oe | addr_strobe);
    endfunction

    // every cycle: nothing may be driven under backoff or hold
    always @(negedge clk) begin
        if (!finished && bus_reset === 1'b0) begin
            if (backoff === 1'b1) chk("R1", "pins driven under backoff", drive_any(), 0);
            if (hold_ack === 1'b1) chk("R3", "pins driven under hold", drive_any(), 0);
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        chk("WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    // full access with the given attributes; starts in idle
    task automatic do_access(bit dc, bit dma, bit sup, bit wr);
        acc_req = 1'b1; acc_is_data = dc; acc_is_dma = dma; acc_is_super = sup; acc_is_write = wr;
        #1;
        chk("R11", "accept in idle", int'(acc_accept), 1);
        chk("R5", "bus_req with request", int'(bus_req), 1);
        cyc();
        acc_req = 1'b0;
        acc_is_data = !dc; acc_is_dma = !dma; acc_is_super = !sup; acc_is_write = !wr;
        #1;
        chk("R11", "strobe cycle", int'(addr_strobe), 1);
        chk("R6", "attr_oe in access", int'(attr_oe), 1);
        chk("R6", "attr_dc value", int'(attr_dc), int'(dc));
        chk("R6", "attr_dma value", int'(attr_dma), int'(dma));
        chk("R6", "attr_sup value", int'(attr_sup), int'(sup));
        chk("R7", "wr_dir value", int'(wr_dir), int'(wr));
        for (int b = 0; b < BEATS; b++) begin
            cyc();
            chk("R11", "no strobe in data", int'(addr_strobe), 0);
            chk("R11", "addr_oe in data", int'(addr_oe), 1);
            chk("R11", "data_oe follows write", int'(data_oe), int'(wr));
            chk("R11", "done on last beat", int'(acc_done), int'(b == BEATS - 1));
            chk("R5", "bus_req in access", int'(bus_req), 1);
        end
        cyc();
        chk("R6", "attr_oe idle", int'(attr_oe), 0);
        chk("R11", "addr_oe idle", int'(addr_oe), 0);
        chk("R5", "bus_req idle", int'(bus_req), 0);
    endtask

    // count data cycles until done, after the resume strobe cycle
    task automatic count_rest(string req, int exp);
        int n = 0;
        do begin
            cyc();
            n++;
        end while (!acc_done && n < BEATS + 3);
        chk(req, "remaining beats after resume", n, exp);
        cyc();
        chk(req, "idle after resumed access", int'(addr_oe), 0);
    endtask

    initial begin
        bus_reset = 1'b1; acc_req = 1'b0; acc_is_data = 1'b0; acc_is_dma = 1'b0;
        acc_is_super = 1'b0; acc_is_write = 1'b0; hold_req = 1'b0; backoff = 1'b0;
        cyc(); cyc();
        // reset state
        chk("R4", "hold_ack at reset", int'(hold_ack), 0);
        chk("R6", "attr_oe at reset", int'(attr_oe), 0);
        acc_req = 1'b1;
        #1;
        chk("R5", "bus_req low in reset", int'(bus_req), 0);
        chk("R11", "no accept in reset", int'(acc_accept), 0);
        acc_req = 1'b0;
        // hold granted under reset
        hold_req = 1'b1;
        cyc();
        chk("R4", "hold granted in reset", int'(hold_ack), 1);
        chk("R5", "bus_req in reset hold", int'(bus_req), 0);
        chk("R6", "attr floated in reset hold", int'(attr_oe), 0);
        hold_req = 1'b0;
        cyc();
        chk("R10", "hold dropped in reset", int'(hold_ack), 0);
        bus_reset = 1'b0;
        cyc();

        // exhaustive attribute / direction sweep
        for (int v = 0; v < 16; v++) begin
            do_access(v[0], v[1], v[2], v[3]);
        end

        // backoff at each beat position
        for (int k = 0; k < BEATS; k++) begin
            acc_req = 1'b1; acc_is_write = 1'b1; acc_is_data = 1'b1;
            cyc();
            acc_req = 1'b0;
            for (int b = 0; b <= k; b++) cyc();  // now in data beat k
            backoff = 1'b1;
            #1;
            chk("R1", "no done under backoff", int'(acc_done), 0);
            chk("R1", "floated under backoff", drive_any(), 0);
            chk("R5", "bus_req under backoff", int'(bus_req), 1);
            cyc(); cyc();
            backoff = 1'b0;
            #1;
            chk("R2", "no strobe before release edge", int'(addr_strobe), 0);
            cyc();
            chk("R2", "resume strobe", int'(addr_strobe), 1);
            count_rest("R2", BEATS - k);
        end

        // hold arriving mid access
        acc_req = 1'b1; acc_is_write = 1'b0;
        cyc();
        acc_req = 1'b0;
        hold_req = 1'b1;
        for (int b = 0; b < BEATS; b++) begin
            cyc();
            chk("R8", "no hold mid access", int'(hold_ack), 0);
        end
        chk("R8", "last beat before hold", int'(acc_done), 1);
        cyc();
        chk("R8", "hold after access end", int'(hold_ack), 1);
        acc_req = 1'b1;
        #1;
        chk("R5", "bus_req during hold", int'(bus_req), 1);
        chk("R8", "no accept during hold", int'(acc_accept), 0);
        cyc();
        chk("R3", "hold kept", int'(hold_ack), 1);
        hold_req = 1'b0;
        cyc();
        chk("R10", "hold_ack falls", int'(hold_ack), 0);
        chk("R10", "pins still floated", drive_any(), 0);
        cyc();
        acc_req = 1'b0;
        chk("R10", "strobe one cycle later", int'(addr_strobe), 1);
        for (int b = 0; b < BEATS; b++) cyc();
        chk("R11", "done after hold access", int'(acc_done), 1);
        cyc();

        // backoff and hold together
        acc_req = 1'b1;
        cyc();
        acc_req = 1'b0;
        cyc();  // data beat 0
        backoff = 1'b1; hold_req = 1'b1;
        cyc();
        chk("R9", "backoff first, no hold", int'(hold_ack), 0);
        backoff = 1'b0;
        cyc();
        chk("R9", "hold after backoff release", int'(hold_ack), 1);
        chk("R9", "no strobe while held", int'(addr_strobe), 0);
        chk("R5", "bus_req with suspended access", int'(bus_req), 1);
        cyc();
        chk("R9", "hold kept", int'(hold_ack), 1);
        hold_req = 1'b0;
        cyc();
        chk("R10", "hold_ack falls", int'(hold_ack), 0);
        chk("R10", "no strobe on release", int'(addr_strobe), 0);
        cyc();
        chk("R9", "resume strobe after hold", int'(addr_strobe), 1);
        count_rest("R9", BEATS);

        finish_run();
    end
endmodule